// File: doc/BRIEF.md
# Stack-Processor Port Unit

This block is the input and output port logic of a small 8-bit stack processor. The core hands it the top-of-stack byte as the port address and the byte below it as write data. It also gives one-cycle pulses that mark a port read or a port write. For a read, the block returns a byte, chosen without a clock, from either a plain data input lane or a sticky event catcher. For a write, it loads a registered output port. Either kind of access also produces a registered one-cycle strobe for the port it addressed.

The set of ports is fixed by parameters: the number of input ports, the width of each data input lane, which inputs are event inputs, and the number, width and reset value of each output port. An event input is held in a flag until software reads that port. The read returns all ones while the live input or the flag is high, and the read clears the flag. Reset is synchronous. A parameter selects whether the reset pin is active high or active low.

Top module: `sp_io_unit`

## Requirements
- R1: The read byte is selected combinationally by all 8 bits of the address; an address with no input port (any value of N_IN or above, for example 0x04, 0x80, 0xFF with the default N_IN of 4) reads 0x00.
- R2: A data input whose configured width is under 8 bits reads as its lane bits with zeros above (default port 0 is 5 bits wide, so lane 0xFFFF reads 0x1F).
- R3: A data input whose configured width exceeds 8 bits reads only its low 8 bits (default port 2 is 12 bits, so lane 0x1ABC reads 0xBC); an 8-bit port (default port 1) reads unchanged.
- R4: An event input port (default port 3) reads 0xFF while its live input or its held flag is high and 0x00 otherwise.
- R5: A read command addressed to an event port clears its flag at that clock edge, and this clear wins over an event arriving in the same cycle; a read of any other port leaves the flag alone.
- R6: Outside a clearing read, an event input that is high sets the flag, and the flag then holds until the next read of that port.
- R7: Input strobe k is high for exactly the one cycle after a read command whose address equals k, and low otherwise.
- R8: Output port k loads the low bits of the write data, as many as its width (default widths 8, 3, 6 for ports 0, 1, 2, shown zero-extended on an 8-bit lane), on a write command whose full 8-bit address equals k, and otherwise keeps its value.
- R9: Reset puts each output port at its configured initial value (defaults 0x00, 0x05, 0x2A for ports 0, 1, 2).
- R10: Output strobe k is high for exactly the one cycle after a write command addressed to k, and low otherwise.
- R11: Reset is synchronous; with the default active-high setting, commands given while reset is high change no output and all strobes stay low.
- R12: A read command and a write command in the same cycle are each carried out independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| i_rst | input | 1 | Synchronous reset, polarity set by RST_ACTIVE_LOW |
| i_rd_cmd | input | 1 | One-cycle port read command |
| i_wr_cmd | input | 1 | One-cycle port write command |
| i_addr | input | 8 | Port address (top of stack) |
| i_wdata | input | 8 | Write data (next on stack) |
| i_din | input | N_IN*16 | Data input lanes, 16 bits per input port |
| i_evt | input | N_IN | Event inputs, one per input port |
| o_rdata | output | 8 | Read byte for the addressed input port |
| o_rd_stb | output | N_IN | Registered input strobes |
| o_wr_stb | output | N_OUT | Registered output strobes |
| o_dout | output | N_OUT*8 | Output port registers, 8 bits per port |

## Verification
The read byte is combinational. The bench samples it 1 ns after driving the address and event inputs, before the clock edge that would move the event flag, and checks the cleared flag on the following cycle. Strobes and output registers change at the edge after the command. For each command the driver queues the expected strobe and output values, and a monitor compares them 2 ns after that edge. This catches a strobe that comes a cycle late or lasts a second cycle, because the next queued item expects it low.

// File: rtl/sp_io_pkg.sv
package sp_io_pkg;
   localparam int unsigned SP_DW   = 8;   // processor data width
   localparam int unsigned LANE_W  = 16;  // input lane width per port
   localparam int unsigned IW_FLD  = 5;   // bits per input width field
   localparam int unsigned OW_FLD  = 4;   // bits per output width field
   typedef logic [SP_DW-1:0] sp_byte_t;
endpackage

// File: rtl/sp_io_evt_latch.sv
module sp_io_evt_latch (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic set,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (rst)      flag <= 1'b0;
      else if (clr) flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end

   AST_EVT_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
      clr |=> !flag);                                   // R5
   AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
      (!clr && set) |=> flag);                          // R6
   AST_EVT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!clr && !set) |=> $stable(flag));                // R6
endmodule

// File: rtl/sp_io_in_side.sv
module sp_io_in_side
   import sp_io_pkg::*;
#(
   parameter int unsigned             N_IN      = 4,
   parameter logic [N_IN*IW_FLD-1:0]  IN_WIDTHS = '1,
   parameter logic [N_IN-1:0]         IN_EVENT  = '0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    rd_cmd,
   input  sp_byte_t                addr,
   input  logic [N_IN*LANE_W-1:0]  din,
   input  logic [N_IN-1:0]         evt,
   output sp_byte_t                rdata,
   output logic [N_IN-1:0]         rd_stb
);
   sp_byte_t          lane_val [N_IN];
   logic [N_IN-1:0]   hit;
   logic              unused_in_bits;

   assign unused_in_bits = ^din ^ ^evt;

   for (genvar k = 0; k < N_IN; k++) begin : g_port
      localparam int unsigned W = int'(IN_WIDTHS[k*IW_FLD +: IW_FLD]);
      assign hit[k] = (addr == 8'(k));

      if (IN_EVENT[k]) begin : g_evt
         logic flag;
         sp_io_evt_latch u_latch (
            .clk  (clk),
            .rst  (rst),
            .clr  (rd_cmd && hit[k]),
            .set  (evt[k]),
            .flag (flag)
         );
         assign lane_val[k] = (evt[k] || flag) ? 8'hFF : 8'h00;
         AST_EVT_LIVE_READ: assert property (@(posedge clk) disable iff (rst)
            (hit[k] && evt[k]) |-> (rdata == 8'hFF));   // R4
      end else if (W < SP_DW) begin : g_narrow
         assign lane_val[k] = {{(SP_DW-W){1'b0}}, din[k*LANE_W +: W]};
      end else begin : g_wide
         assign lane_val[k] = din[k*LANE_W +: SP_DW];
      end

      AST_RD_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
         (rd_cmd && hit[k]) |=> rd_stb[k]);              // R7
      AST_RD_STB_QUIET: assert property (@(posedge clk) disable iff (rst)
         !(rd_cmd && hit[k]) |=> !rd_stb[k]);            // R7
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < N_IN; k++)
         if (hit[k]) rdata = lane_val[k];
   end

   always_ff @(posedge clk) begin
      if (rst) rd_stb <= '0;
      else     rd_stb <= rd_cmd ? hit : '0;
   end

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
      (addr >= 8'(N_IN)) |-> (rdata == 8'h00));          // R1
endmodule

// File: rtl/sp_io_out_port.sv
module sp_io_out_port
   import sp_io_pkg::*;
#(
   parameter int unsigned W    = 8,
   parameter logic [7:0]  INIT = 8'h00
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     wr,
   input  sp_byte_t wdata,
   output sp_byte_t dout,
   output logic     stb
);
   logic [W-1:0] data_q;
   logic         unused_wbits;

   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= INIT[W-1:0];
         stb    <= 1'b0;
      end else begin
         if (wr) data_q <= wdata[W-1:0];
         stb <= wr;
      end
   end

   if (W < SP_DW) begin : g_pad
      assign dout = {{(SP_DW-W){1'b0}}, data_q};
   end else begin : g_full
      assign dout = data_q;
   end

   AST_OUT_INIT: assert property (@(posedge clk)
      rst |=> (data_q == INIT[W-1:0]));                  // R9
   AST_OUT_LOAD: assert property (@(posedge clk) disable iff (rst)
      wr |=> (data_q == $past(wdata[W-1:0])));           // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr |=> $stable(data_q));                          // R8
   AST_WR_STB_ONE: assert property (@(posedge clk) disable iff (rst)
      stb |=> !stb || $past(wr));                        // R10
endmodule

// File: rtl/sp_io_unit.sv
module sp_io_unit
   import sp_io_pkg::*;
#(
   parameter int unsigned               N_IN           = 4,
   parameter logic [N_IN*IW_FLD-1:0]    IN_WIDTHS      = {5'd1, 5'd12, 5'd8, 5'd5},
   parameter logic [N_IN-1:0]           IN_EVENT       = 4'b1000,
   parameter int unsigned               N_OUT          = 3,
   parameter logic [N_OUT*OW_FLD-1:0]   OUT_WIDTHS     = {4'd6, 4'd3, 4'd8},
   parameter logic [N_OUT*8-1:0]        OUT_INIT       = {8'h2A, 8'h05, 8'h00},
   parameter bit                        RST_ACTIVE_LOW = 1'b0
) (
   input  logic                       clk,
   input  logic                       i_rst,
   input  logic                       i_rd_cmd,
   input  logic                       i_wr_cmd,
   input  logic [7:0]                 i_addr,
   input  logic [7:0]                 i_wdata,
   input  logic [N_IN*LANE_W-1:0]     i_din,
   input  logic [N_IN-1:0]            i_evt,
   output logic [7:0]                 o_rdata,
   output logic [N_IN-1:0]            o_rd_stb,
   output logic [N_OUT-1:0]           o_wr_stb,
   output logic [N_OUT*8-1:0]         o_dout
);
   logic rst;

   if (N_IN < 1 || N_IN > 256) begin : g_bad_nin
      $error("sp_io_unit: N_IN must be 1..256");
   end
   if (N_OUT < 1 || N_OUT > 256) begin : g_bad_nout
      $error("sp_io_unit: N_OUT must be 1..256");
   end

   if (RST_ACTIVE_LOW) begin : g_rst_n
      assign rst = ~i_rst;
   end else begin : g_rst_p
      assign rst = i_rst;
   end

   for (genvar k = 0; k < N_IN; k++) begin : g_chk_iw
      if (IN_WIDTHS[k*IW_FLD +: IW_FLD] == 0 || int'(IN_WIDTHS[k*IW_FLD +: IW_FLD]) > LANE_W) begin : g_bad
         $error("sp_io_unit: input width out of range");
      end
   end

   sp_io_in_side #(
      .N_IN      (N_IN),
      .IN_WIDTHS (IN_WIDTHS),
      .IN_EVENT  (IN_EVENT)
   ) u_in (
      .clk    (clk),
      .rst    (rst),
      .rd_cmd (i_rd_cmd),
      .addr   (i_addr),
      .din    (i_din),
      .evt    (i_evt),
      .rdata  (o_rdata),
      .rd_stb (o_rd_stb)
   );

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      localparam int unsigned OW = int'(OUT_WIDTHS[k*OW_FLD +: OW_FLD]);
      if (OW == 0 || OW > SP_DW) begin : g_bad
         $error("sp_io_unit: output width out of range");
      end
      sp_io_out_port #(
         .W    (OW),
         .INIT (OUT_INIT[k*8 +: 8])
      ) u_port (
         .clk   (clk),
         .rst   (rst),
         .wr    (i_wr_cmd && (i_addr == 8'(k))),
         .wdata (i_wdata),
         .dout  (o_dout[k*8 +: 8]),
         .stb   (o_wr_stb[k])
      );
   end

   AST_WR_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(o_wr_stb));                               // R10
   AST_RD_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $onehot0(o_rd_stb));                               // R7
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (o_rd_stb == '0 && o_wr_stb == '0));       // R11
endmodule

// File: tb/sp_io_unit_tb.sv
module sp_io_unit_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        rd_cmd, wr_cmd;
   logic [7:0]  addr, wdata;
   logic [63:0] din;
   logic [3:0]  evt;
   logic [7:0]  rdata;
   logic [3:0]  rd_stb;
   logic [2:0]  wr_stb;
   logic [23:0] dout;

   int n_tests = 0;
   int n_fail  = 0;

   logic [3:0]  q_rs [$];
   logic [2:0]  q_ws [$];
   logic [23:0] q_do [$];
   string       q_tag [$];
   logic [7:0]  eo [3];

   always #4 clk = ~clk;   // 125 MHz

   sp_io_unit u_dut (
      .clk      (clk),
      .i_rst    (rst),
      .i_rd_cmd (rd_cmd),
      .i_wr_cmd (wr_cmd),
      .i_addr   (addr),
      .i_wdata  (wdata),
      .i_din    (din),
      .i_evt    (evt),
      .o_rdata  (rdata),
      .o_rd_stb (rd_stb),
      .o_wr_stb (wr_stb),
      .o_dout   (dout)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: applies one command cycle and queues the post-edge expectation
   task automatic step(input logic ip, input logic op, input logic [7:0] a,
                       input logic [7:0] d, input logic [3:0] ev, input string tag);
      logic [3:0] ers;
      logic [2:0] ews;
      @(negedge clk);
      rd_cmd = ip; wr_cmd = op; addr = a; wdata = d; evt = ev;
      ers = (ip && a < 8'd4) ? 4'(1 << a) : 4'd0;
      ews = (op && a < 8'd3) ? 3'(1 << a) : 3'd0;
      if (op && a == 8'd0) eo[0] = d;
      if (op && a == 8'd1) eo[1] = d & 8'h07;
      if (op && a == 8'd2) eo[2] = d & 8'h3F;
      q_rs.push_back(ers);
      q_ws.push_back(ews);
      q_do.push_back({eo[2], eo[1], eo[0]});
      q_tag.push_back(tag);
   endtask

   task automatic rd_is(input logic [7:0] exp, input string tag);
      #1 chk(tag, 32'(rdata), 32'(exp));
   endtask

   // monitor: compares registered results after each edge
   always @(posedge clk) begin
      #2;
      if (q_tag.size() > 0) begin
         string tg;
         tg = q_tag.pop_front();
         chk({tg, " rd_stb"}, 32'(rd_stb), 32'(q_rs.pop_front()));
         chk({tg, " wr_stb"}, 32'(wr_stb), 32'(q_ws.pop_front()));
         chk({tg, " dout"},   32'(dout),   32'(q_do.pop_front()));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1; rd_cmd = 0; wr_cmd = 0; addr = 0; wdata = 0; evt = 0;
      din = {16'h0000, 16'h1ABC, 16'h005A, 16'hFFFF};
      eo[0] = 8'h00; eo[1] = 8'h05; eo[2] = 8'h2A;
      repeat (3) @(negedge clk);
      chk("R9 reset init", 32'(dout), 32'h2A0500);
      chk("R11 reset rd_stb", 32'(rd_stb), 0);
      chk("R11 reset wr_stb", 32'(wr_stb), 0);
      wr_cmd = 1; rd_cmd = 1; addr = 8'd0; wdata = 8'hFF;
      @(negedge clk);
      chk("R11 write in reset ignored", 32'(dout), 32'h2A0500);
      chk("R11 strobe in reset", 32'({rd_stb, wr_stb}), 0);
      rst = 1'b0; rd_cmd = 0; wr_cmd = 0;

      // R1/R2/R3 read mux
      step(0,0,8'h00,0,0,"R2 narrow"); rd_is(8'h1F, "R2 narrow port zero-extended");
      step(0,0,8'h01,0,0,"R3 exact");  rd_is(8'h5A, "R3 8-bit port");
      step(0,0,8'h02,0,0,"R3 wide");   rd_is(8'hBC, "R3 wide port low byte");
      step(0,0,8'h04,0,0,"R1 unmapped"); rd_is(8'h00, "R1 addr 0x04");
      step(0,0,8'h80,0,0,"R1 unmapped"); rd_is(8'h00, "R1 addr 0x80");
      step(0,0,8'hFF,0,0,"R1 unmapped"); rd_is(8'h00, "R1 addr 0xFF");
      step(1,0,8'h02,0,0,"R7 read strobe port2"); rd_is(8'hBC, "R7 read value");
      step(1,0,8'h07,0,0,"R7 unmapped read no strobe");
      step(0,0,8'h00,0,0,"R7 strobe drops");

      // event port 3
      step(0,0,8'h03,0,4'b0000,"R4 idle");   rd_is(8'h00, "R4 idle reads zero");
      step(0,0,8'h03,0,4'b1000,"R4 live");   rd_is(8'hFF, "R4 live event");
      step(0,0,8'h03,0,4'b0000,"R6 held");   rd_is(8'hFF, "R6 flag held");
      step(1,0,8'h01,0,4'b0000,"R5 other read"); rd_is(8'h5A, "R5 other port read");
      step(0,0,8'h03,0,4'b0000,"R5 not cleared"); rd_is(8'hFF, "R5 other read keeps flag");
      step(1,0,8'h03,0,4'b0000,"R5 clearing read"); rd_is(8'hFF, "R4 read sees flag");
      step(0,0,8'h03,0,4'b0000,"R5 cleared"); rd_is(8'h00, "R5 flag cleared");
      step(1,0,8'h03,0,4'b1000,"R5 same-cycle"); rd_is(8'hFF, "R4 live during read");
      step(0,0,8'h03,0,4'b0000,"R5 lost"); rd_is(8'h00, "R5 same-cycle event lost");
      step(0,0,8'h03,0,4'b1000,"R6 later event"); rd_is(8'hFF, "R6 later event live");
      step(0,0,8'h03,0,4'b0000,"R6 hold1"); rd_is(8'hFF, "R6 held after event");
      step(0,0,8'h00,0,4'b0000,"R6 hold2");
      step(0,0,8'h03,0,4'b0000,"R6 hold3"); rd_is(8'hFF, "R6 still held");
      step(1,0,8'h03,0,4'b0000,"R6 next read"); rd_is(8'hFF, "R6 read returns held");
      step(0,0,8'h03,0,4'b0000,"R5 cleared again"); rd_is(8'h00, "R5 cleared by next read");

      // outputs
      step(0,1,8'h01,8'hFF,0,"R8 port1 3-bit load");
      step(0,1,8'h00,8'hA5,0,"R8 port0 load");
      step(0,1,8'h02,8'hFF,0,"R8 port2 6-bit load");
      step(0,1,8'h03,8'h11,0,"R8 unmapped write");
      step(0,1,8'h81,8'h00,0,"R8 full address compare");
      step(0,0,8'h01,8'h00,0,"R10 hold no strobe");
      step(1,1,8'h00,8'h33,0,"R12 read and write together");
      step(0,0,8'h00,8'h00,0,"R12 strobes clear");
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule